// File: doc/BRIEF.md
# Echo Canceller Channel Mode Controller

This block wraps one channel of an adaptive echo canceller. It takes one pair of PCM samples per 125 µs frame. The near-end sample arrives on the send side and the far-end reference on the receive side. For each pair it returns one output pair. Four mode controls decide what that output carries:

- **mute_rx** forces the quiet code onto the receive-direction output.
- **mute_tx** forces the quiet code onto the send-direction output.
- **bypass** passes both samples through unchanged and wipes the filter coefficients.
- **adapt_off** freezes the coefficients while cancellation goes on.

The filter is a small stub, not a full LMS engine. It keeps TAPS coefficients and builds an echo estimate from delayed receive samples. It subtracts that estimate from the delayed send sample. While adaptation runs, it nudges each coefficient by a sign-sign step.

Samples are treated as signed 8-bit linear values in this stub. All delay stages start at zero.

Both data edges are valid/ready streams, and each accepted input beat is one frame. Back-pressure works as follows:

- An input beat is accepted only when `in_ready` is high, and `in_ready` is high whenever the output register is empty or is being drained in the same cycle.
- A held output beat keeps its data unchanged until `out_ready` takes it.
- Frames are counted in accepted beats, never in clock cycles.

The four mode controls are plain pins, captured when a beat is accepted.

Top module: `ecc_channel_ctrl`

## Requirements
- R1: After reset, `out_valid` and `clear_done` are 0 and `in_ready` is 1. The mode in force is bypass with both mutes off and adaptation on. All coefficients and all delay stages hold zero.
- R2: Each accepted input beat yields exactly one output beat, in order. `in_ready` equals `!out_valid || out_ready`. While `out_valid && !out_ready`, the output data stay stable.
- R3: The mode pins are captured when a beat is accepted and govern the following accepted beat. The beat that captures them runs under the previously captured mode.
- R4: With mute_rx in force, `out_rout` is the QUIET parameter (default 8'hFF).
- R5: With mute_tx in force, `out_sout` is QUIET, and this overrides both bypass and cancellation.
- R6: In bypass, `out_rout` of beat k equals `in_rin` of beat k-2, and `out_sout` of beat k equals `in_sin` of beat k-2.
- R7: Outside bypass, `out_rout` of beat k equals `in_rin` of beat k-2. `out_sout` of beat k is the cancelled value of `in_sin` from beat k-3.
- R8: The cancelled value is saturate8(s - (Σj c[j]·x[j] >>> EST_SHIFT)). Here s = `in_sin` of beat k-3, x[j] = `in_rin` of beat k-3-j, the shift is arithmetic, and EST_SHIFT defaults to 4.
- R9: With adaptation on and bypass off, each beat updates c[j] by sign(e)·sign(x[j]), where e is that beat's cancelled value. Each coefficient saturates at the signed COEF_W range.
- R10: With adaptation off, coefficients keep their values while cancellation continues with them.
- R11: Every beat run in bypass sets all coefficients to zero. The first beat after bypass cancels with all-zero coefficients.
- R12: `clear_done` goes to 1 after a beat run in bypass, and to 0 after a beat run outside bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample pair offered |
| in_ready | output | 1 | Input pair can be taken |
| in_rin | input | 8 | Receive-side input sample |
| in_sin | input | 8 | Send-side input sample |
| mute_rx | input | 1 | Quiet code on receive output |
| mute_tx | input | 1 | Quiet code on send output |
| bypass | input | 1 | Pass-through, clears coefficients |
| adapt_off | input | 1 | Freeze coefficients |
| out_valid | output | 1 | Output sample pair present |
| out_ready | input | 1 | Consumer takes the output pair |
| out_rout | output | 8 | Receive-side output sample |
| out_sout | output | 8 | Send-side output sample |
| clear_done | output | 1 | Last frame ran in bypass; coefficients are zero |

## Verification
A coefficient that is wrong, or that was left uncleared, shows at the ports within one to two frames. `out_sout` departs from the cancelled value that the sign-sign model predicts. After a single bypass frame, that departure shows in the very first normal beat. A delay stage that is off by one corrupts `out_rout` or the bypass `out_sout` on the first beat whose history differs. Mode capture a beat early or late shows on the transition beat itself. Random back-pressure exercises stall stability and in-order delivery throughout.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  typedef struct packed {
    logic mute_rx;
    logic mute_tx;
    logic bypass;
    logic adapt_off;
  } ecc_mode_t;

  localparam ecc_mode_t MODE_AT_RESET = '{mute_rx: 1'b0, mute_tx: 1'b0,
                                          bypass: 1'b1, adapt_off: 1'b0};
endpackage

// File: rtl/ecc_mode_reg.sv
module ecc_mode_reg
  import ecc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      advance,
  input  ecc_mode_t ctl_in,
  output ecc_mode_t mode_q,
  output logic      clear_done
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= MODE_AT_RESET;
      clear_done <= 1'b0;
    end else if (advance) begin
      mode_q     <= ctl_in;
      clear_done <= mode_q.bypass;
    end
  end

  // R12
  clear_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    advance && mode_q.bypass |=> clear_done);

  // R3
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(mode_q));
endmodule

// File: rtl/ecc_delay_line.sv
module ecc_delay_line #(
  parameter int W     = 8,
  parameter int DEPTH = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      shift,
  input  logic [W-1:0]              din,
  output logic [DEPTH-1:0][W-1:0]   taps
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n)
        taps[i] <= '0;
      else if (shift) begin
        if (i == 0) taps[i] <= din;
        else        taps[i] <= taps[(i == 0) ? 0 : i-1];
      end
    end
  end

  // R2
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift |=> $stable(taps));
endmodule

// File: rtl/ecc_filter_stub.sv
module ecc_filter_stub #(
  parameter int W     = 8,
  parameter int CW    = 8,
  parameter int TAPS  = 2,
  parameter int SHIFT = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    step,
  input  logic                    clear,
  input  logic                    freeze,
  input  logic [TAPS-1:0][W-1:0]  refs,
  input  logic [W-1:0]            near,
  output logic [W-1:0]            err
);
  localparam int ACC_W = W + CW + $clog2(TAPS) + 1;
  localparam logic signed [ACC_W-1:0] E_MAX = (ACC_W)'((2 ** (W-1)) - 1);
  localparam logic signed [ACC_W-1:0] E_MIN = -E_MAX - (ACC_W)'(1);
  localparam logic signed [CW:0]      C_MAX = (CW+1)'((2 ** (CW-1)) - 1);
  localparam logic signed [CW:0]      C_MIN = -C_MAX - (CW+1)'(1);

  logic signed [CW-1:0]   coef_q [TAPS];
  logic signed [W+CW-1:0] prod   [TAPS];
  logic signed [CW:0]     nxt    [TAPS];
  logic signed [ACC_W-1:0] acc, est, diff;

  function automatic logic signed [1:0] sgn(input logic signed [W-1:0] v);
    if (v == '0)  return 2'sd0;
    else if (v[W-1]) return -2'sd1;
    else          return 2'sd1;
  endfunction

  always_comb begin
    acc = '0;
    for (int i = 0; i < TAPS; i++) begin
      prod[i] = coef_q[i] * $signed(refs[i]);
      acc     = acc + (ACC_W)'(prod[i]);
    end
    est  = acc >>> SHIFT;
    diff = (ACC_W)'($signed(near)) - est;
    if (diff > E_MAX)      err = E_MAX[W-1:0];
    else if (diff < E_MIN) err = E_MIN[W-1:0];
    else                   err = diff[W-1:0];
  end

  always_comb begin
    for (int i = 0; i < TAPS; i++)
      nxt[i] = (CW+1)'(coef_q[i]) + (CW+1)'(sgn(err) * sgn(refs[i]));
  end

  for (genvar i = 0; i < TAPS; i++) begin : g_coef
    always_ff @(posedge clk) begin
      if (!rst_n)
        coef_q[i] <= '0;
      else if (step) begin
        if (clear)             coef_q[i] <= '0;
        else if (!freeze) begin
          if (nxt[i] > C_MAX)      coef_q[i] <= C_MAX[CW-1:0];
          else if (nxt[i] < C_MIN) coef_q[i] <= C_MIN[CW-1:0];
          else                     coef_q[i] <= nxt[i][CW-1:0];
        end
      end
    end

    // R11
    coef_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step && clear |=> coef_q[i] == '0);

    // R10
    coef_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step && freeze && !clear |=> $stable(coef_q[i]));

    // R9
    coef_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step && !freeze && !clear |=>
        ($signed(coef_q[i]) - $signed($past(coef_q[i])) <= 1) &&
        ($signed($past(coef_q[i])) - $signed(coef_q[i]) <= 1));
  end
endmodule

// File: rtl/ecc_channel_ctrl.sv
module ecc_channel_ctrl
  import ecc_pkg::*;
#(
  parameter int          TAPS      = 2,
  parameter int          COEF_W    = 8,
  parameter int          EST_SHIFT = 4,
  parameter logic [7:0]  QUIET     = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_rin,
  input  logic [7:0] in_sin,
  input  logic       mute_rx,
  input  logic       mute_tx,
  input  logic       bypass,
  input  logic       adapt_off,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_rout,
  output logic [7:0] out_sout,
  output logic       clear_done
);
  localparam int W       = 8;
  localparam int R_DEPTH = 2 + TAPS;
  localparam int S_DEPTH = 3;
  localparam int RX_LAT  = 2;
  localparam int BY_LAT  = 2;

  ecc_mode_t                  mode_q, ctl_in;
  logic                       accept;
  logic [R_DEPTH-1:0][W-1:0]  r_taps;
  logic [S_DEPTH-1:0][W-1:0]  s_taps;
  logic [TAPS-1:0][W-1:0]     refs;
  logic [W-1:0]               err;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign ctl_in   = '{mute_rx: mute_rx, mute_tx: mute_tx,
                      bypass: bypass, adapt_off: adapt_off};

  ecc_mode_reg u_mode (
    .clk, .rst_n, .advance(accept), .ctl_in,
    .mode_q, .clear_done
  );

  ecc_delay_line #(.W(W), .DEPTH(R_DEPTH)) u_rhist (
    .clk, .rst_n, .shift(accept), .din(in_rin), .taps(r_taps)
  );

  ecc_delay_line #(.W(W), .DEPTH(S_DEPTH)) u_shist (
    .clk, .rst_n, .shift(accept), .din(in_sin), .taps(s_taps)
  );

  for (genvar j = 0; j < TAPS; j++) begin : g_ref
    assign refs[j] = r_taps[S_DEPTH-1+j];
  end

  ecc_filter_stub #(.W(W), .CW(COEF_W), .TAPS(TAPS), .SHIFT(EST_SHIFT)) u_filt (
    .clk, .rst_n, .step(accept), .clear(mode_q.bypass),
    .freeze(mode_q.adapt_off), .refs, .near(s_taps[S_DEPTH-1]), .err
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rout  <= '0;
      out_sout  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_rout  <= mode_q.mute_rx ? QUIET : r_taps[RX_LAT-1];
      if (mode_q.mute_tx)     out_sout <= QUIET;
      else if (mode_q.bypass) out_sout <= s_taps[BY_LAT-1];
      else                    out_sout <= err;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_rout) && $stable(out_sout));

  // R4
  mute_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && mode_q.mute_rx |=> out_rout == QUIET);

  // R5
  mute_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && mode_q.mute_tx |=> out_sout == QUIET);

  // R6
  bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && mode_q.bypass && !mode_q.mute_tx |=> out_sout == $past(s_taps[BY_LAT-1]));

  // R7
  rx_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !mode_q.mute_rx |=> out_rout == $past(r_taps[RX_LAT-1]));
endmodule

// File: tb/ecc_channel_ctrl_test.sv
`timescale 1ns/1ps
module ecc_channel_ctrl_test;
  localparam int TAPS = 2;
  localparam logic [7:0] QUIET = 8'hFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [7:0] in_rin = '0, in_sin = '0;
  logic mute_rx = 1'b0, mute_tx = 1'b0, bypass = 1'b0, adapt_off = 1'b0;
  logic out_valid, out_ready, clear_done;
  logic [7:0] out_rout, out_sout;

  ecc_channel_ctrl #(.TAPS(TAPS)) uut (
    .clk, .rst_n, .in_valid, .in_ready, .in_rin, .in_sin,
    .mute_rx, .mute_tx, .bypass, .adapt_off,
    .out_valid, .out_ready, .out_rout, .out_sout, .clear_done
  );

  always #4 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  int ready_pct = 100;
  logic [15:0] expq[$];

  // reference model state
  int rh[TAPS+2];
  int sh[3];
  int cf[TAPS];
  bit m_mr = 0, m_ms = 0, m_bp = 1, m_ad = 0, m_clr = 0;

  function automatic int sx(input int v); return (v > 127) ? v - 256 : v; endfunction
  function automatic int sat(input int v, input int lim);
    if (v > lim) return lim;
    if (v < -lim-1) return -lim-1;
    return v;
  endfunction
  function automatic int sg(input int v); return (v > 0) ? 1 : (v < 0) ? -1 : 0; endfunction

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R3: model runs each beat under the mode captured on the previous beat
  task automatic model(input int r, input int s, input bit mr, input bit ms,
                       input bit bp, input bit ad);
    int acc, e, ro, so;
    ro = m_mr ? QUIET : rh[1];
    acc = 0;
    for (int j = 0; j < TAPS; j++) acc += cf[j] * sx(rh[2+j]);
    e = sat(sx(sh[2]) - (acc >>> 4), 127);
    so = m_ms ? QUIET : (m_bp ? sh[1] : (e & 255));
    expq.push_back({ro[7:0], so[7:0]});
    if (m_bp) for (int j = 0; j < TAPS; j++) cf[j] = 0;
    else if (!m_ad) for (int j = 0; j < TAPS; j++) cf[j] = sat(cf[j] + sg(e) * sg(sx(rh[2+j])), 127);
    m_clr = m_bp;
    for (int j = TAPS+1; j > 0; j--) rh[j] = rh[j-1];
    rh[0] = r;
    sh[2] = sh[1]; sh[1] = sh[0]; sh[0] = s;
    m_mr = mr; m_ms = ms; m_bp = bp; m_ad = ad;
  endtask

  task automatic send(input int r, input int s, input bit mr, input bit ms,
                      input bit bp, input bit ad);
    in_rin = r[7:0]; in_sin = s[7:0];
    mute_rx = mr; mute_tx = ms; bypass = bp; adapt_off = ad;
    in_valid = 1'b1;
    forever begin
      #1;
      if (in_ready) break;
      @(negedge clk);
    end
    model(r, s, mr, ms, bp, ad);
    @(posedge clk); #1;
    check("R12 clear_done", clear_done, m_clr);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor: scoreboard pop and compare
  initial begin
    logic [15:0] e;
    out_ready = 1'b0;
    forever begin
      @(negedge clk);
      out_ready <= (($urandom % 100) < ready_pct);
      #2;
      if (rst_n && out_valid && out_ready) begin
        if (expq.size() == 0) check("R2 extra beat", 1, 0);
        else begin
          e = expq.pop_front();
          check("R2/R4/R6/R7 rout", out_rout, e[15:8]);
          check("R5/R6/R7/R8/R9 sout", out_sout, e[7:0]);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int r, s;
    for (int j = 0; j < TAPS+2; j++) rh[j] = 0;
    for (int j = 0; j < 3; j++) sh[j] = 0;
    for (int j = 0; j < TAPS; j++) cf[j] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 out_valid", out_valid, 0);
    check("R1 clear_done", clear_done, 0);
    #1 check("R1 in_ready", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    // R6 bypass pass-through, R12 clear flag
    for (int i = 0; i < 6; i++) send($urandom % 256, $urandom % 256, 0, 0, 1, 0);
    // R7 R8 R9 normal cancellation with adapting coefficients and echo
    for (int i = 0; i < 80; i++) begin
      r = $urandom % 256;
      s = (sx(rh[1]) / 2 + sx(rh[2]) / 4 + int'($urandom % 9) - 4) & 255;
      send(r, s, 0, 0, 0, 0);
    end
    // R4 R5 mutes, with mute_tx over bypass
    send(10, 20, 1, 0, 0, 0);
    send(30, 40, 0, 1, 0, 0);
    send(50, 60, 1, 1, 1, 0);
    send(70, 80, 0, 1, 1, 0);
    send(90, 100, 0, 0, 0, 0);
    send(11, 22, 0, 0, 0, 0);
    // R10 frozen coefficients, cancellation continues
    for (int i = 0; i < 20; i++) send($urandom % 256, $urandom % 256, 0, 0, 0, 1);
    // R11 single bypass beat clears coefficients
    send(5, 6, 0, 0, 1, 0);
    for (int i = 0; i < 8; i++) send($urandom % 256, $urandom % 256, 0, 0, 0, 0);
    // R2 heavy back-pressure with random modes, R3 captured mode timing
    ready_pct = 30;
    for (int i = 0; i < 60; i++)
      send($urandom % 256, $urandom % 256, ($urandom % 5) == 0, ($urandom % 5) == 0,
           ($urandom % 6) == 0, ($urandom % 3) == 0);
    ready_pct = 100;
    repeat (20) @(negedge clk);
    check("R2 drained", expq.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule